// File: doc/BRIEF.md
# One-Wire Accessory Sequence Player

This block drives a single open-drain identification wire on an accessory connector. Software loads a short byte sequence into a local buffer, programs the pulse timings in clock cycles, and issues a start command. The block then plays the bytes least significant bit first. Every bit is a low pulse, short for a one and long for a zero, followed by a released gap. A separate command pulls the wire low for a programmable time and then waits a programmable recovery time, which resets the line. At the end of every bit gap the wire level is sampled, so that a reply from the far end can be read back as raw bits.

The block also owns the two connector pins: the identification wire and the power wire. After reset both pins belong to the player. The player never drives a pin high; it only pulls a pin low or releases it. A sequence such as the debug-entry pattern starting 0x75, 0xA0 can be started with an arm bit set. When that sequence completes, the pins pass permanently to an external serial debug engine. The identification wire then becomes the bidirectional debug data line and the power wire becomes the debug clock. All control and status goes through a simple Wishbone-style register port.

Top module: `owire_seq_player`

## Requirements
- R1: After reset the line and power pins are released (output-enables 0, outputs 0), the debug data input seen by the engine reads 1, and STATUS (word address 1) reads 0.
- R2: Writing CTRL (word address 0) with bit 0 set while idle plays LEN (address 2) bytes from buffer entries at addresses 16 and up, in index order and LSB first. A 1 bit drives the line low for T_ONE (address 3) cycles and a 0 bit for T_ZERO (address 4) cycles. Each low pulse is followed by T_GAP (address 5) released cycles. The low pulse starts in the cycle after the write is accepted. A LEN value above the buffer depth is stored as the depth.
- R3: While the player owns the pins, the identification output value is 0 and the power pin is never enabled: the line is only pulled low or released.
- R4: STATUS bit 0 (busy) is 1 from the accepted command until the last recovery cycle ends. A start or reset command written while busy is ignored, and a start with LEN equal to 0 is ignored.
- R5: STATUS bit 1 (done) is set when a sequence or a line reset completes. It stays set until a STATUS write with bit 1 set clears it.
- R6: Writing CTRL bit 1 while idle holds the line low for T_RST (address 6) cycles and then released for T_RREC (address 7) cycles. If bits 0 and 1 are written together, only the reset runs.
- R7: If CTRL bit 2 was set in the accepted start write, then when that sequence ends STATUS bit 2 rises and stays at 1 until reset. From then on the identification pin carries the debug data output and enable, the power pin is driven with the debug clock, and the debug data input follows the identification pin. Without the arm bit the pins stay with the player.
- R8: A timing register written with 0 behaves as 1 cycle.
- R9: In the last cycle of each bit gap the line level is shifted into STATUS bits 15:8 from the top, so after eight bits the first sampled bit sits in bit 8.
- R10: Each accepted bus request is acknowledged for exactly one cycle, one cycle after it is presented. The timing and LEN registers read back their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 5 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| pin_id_in | input | 1 | Level sensed on the identification pin |
| pin_id_out | output | 1 | Identification pin output value |
| pin_id_oe | output | 1 | Identification pin output enable |
| pin_pwr_out | output | 1 | Power pin output value |
| pin_pwr_oe | output | 1 | Power pin output enable |
| dbg_dio_out | input | 1 | Debug engine data output |
| dbg_dio_oe | input | 1 | Debug engine data output enable |
| dbg_clk_out | input | 1 | Debug engine clock |
| dbg_dio_in | output | 1 | Data level returned to the debug engine |

## Verification
The hardest states to reach are commands that arrive while the engine is already running. The bench writes a second start and a reset right after a start is accepted, and the run must carry on unchanged. Reply sampling needs the far end to pull the wire low in the sampling cycle. The bench models an accessory that can hold the wire low, so the receive byte reads both all ones and all zeros. The pin handover is one-way, so it is left for the last run. After it, the bench drives every combination of debug engine outputs through the pins.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE = 3'd0,
        ENG_LOW  = 3'd1,
        ENG_GAP  = 3'd2,
        ENG_RLOW = 3'd3,
        ENG_RREC = 3'd4
    } eng_state_e;

    // register word addresses (below the buffer window)
    localparam int REG_CTRL  = 0;
    localparam int REG_STAT  = 1;
    localparam int REG_LEN   = 2;
    localparam int REG_TONE  = 3;
    localparam int REG_TZERO = 4;
    localparam int REG_TGAP  = 5;
    localparam int REG_TRST  = 6;
    localparam int REG_TRREC = 7;

    // control and status bit positions
    localparam int CTRL_GO   = 0;
    localparam int CTRL_LRST = 1;
    localparam int CTRL_ARM  = 2;
    localparam int STAT_DONE = 1;

endpackage

// File: rtl/owire_seq_buf.sv
module owire_seq_buf #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [7:0]       wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [7:0]       rdata_o
);

    logic [7:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [7:0] ent_d;
        logic [7:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we_i && (widx_i == IDX_W'(g))) begin
                ent_d = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent[g] = ent_q;
    end

    assign rdata_o = ent[ridx_i];

endmodule

// File: rtl/owire_seq_regs.sv
module owire_seq_regs
    import owire_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int TW     = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    input  logic              busy_i,
    input  logic              dbg_mode_i,
    input  logic [7:0]        rx_i,
    input  logic              done_evt_i,
    output logic              go_o,
    output logic              lrst_o,
    output logic              arm_o,
    output logic [CNT_W-1:0]  len_o,
    output logic [TW-1:0]     t_one_o,
    output logic [TW-1:0]     t_zero_o,
    output logic [TW-1:0]     t_gap_o,
    output logic [TW-1:0]     t_rst_o,
    output logic [TW-1:0]     t_rrec_o,
    output logic              done_o,
    output logic              buf_we_o,
    output logic [IDX_W-1:0]  buf_widx_o,
    output logic [7:0]        buf_wdata_o
);

    localparam int SEL_W = ADDR_W - 1;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic [CNT_W-1:0]  len;
        logic [TW-1:0]     t_one;
        logic [TW-1:0]     t_zero;
        logic [TW-1:0]     t_gap;
        logic [TW-1:0]     t_rst;
        logic [TW-1:0]     t_rrec;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic             req;
    logic             wr;
    logic             is_buf;
    logic [SEL_W-1:0] sel;
    logic             clr_done;

    always_comb begin
        r_d      = r_q;
        req      = wb_cyc_i && wb_stb_i && !r_q.ack;
        wr       = req && wb_we_i;
        is_buf   = wb_adr_i[ADDR_W-1];
        sel      = wb_adr_i[SEL_W-1:0];
        clr_done = 1'b0;

        go_o   = 1'b0;
        lrst_o = 1'b0;
        arm_o  = 1'b0;

        r_d.ack   = req;
        r_d.rdata = '0;

        if (req && !wb_we_i && !is_buf) begin
            case (sel)
                SEL_W'(REG_STAT):  r_d.rdata = DATA_W'({rx_i, 5'b0, dbg_mode_i, r_q.done, busy_i});
                SEL_W'(REG_LEN):   r_d.rdata = DATA_W'(r_q.len);
                SEL_W'(REG_TONE):  r_d.rdata = DATA_W'(r_q.t_one);
                SEL_W'(REG_TZERO): r_d.rdata = DATA_W'(r_q.t_zero);
                SEL_W'(REG_TGAP):  r_d.rdata = DATA_W'(r_q.t_gap);
                SEL_W'(REG_TRST):  r_d.rdata = DATA_W'(r_q.t_rst);
                SEL_W'(REG_TRREC): r_d.rdata = DATA_W'(r_q.t_rrec);
                default:           r_d.rdata = '0;
            endcase
        end

        if (wr && !is_buf) begin
            case (sel)
                SEL_W'(REG_CTRL): begin
                    go_o   = wb_dat_i[CTRL_GO];
                    lrst_o = wb_dat_i[CTRL_LRST];
                    arm_o  = wb_dat_i[CTRL_ARM];
                end
                SEL_W'(REG_STAT):  clr_done = wb_dat_i[STAT_DONE];
                SEL_W'(REG_LEN): begin
                    if (wb_dat_i > DATA_W'(DEPTH)) begin
                        r_d.len = CNT_W'(DEPTH);
                    end else begin
                        r_d.len = wb_dat_i[CNT_W-1:0];
                    end
                end
                SEL_W'(REG_TONE):  r_d.t_one  = wb_dat_i[TW-1:0];
                SEL_W'(REG_TZERO): r_d.t_zero = wb_dat_i[TW-1:0];
                SEL_W'(REG_TGAP):  r_d.t_gap  = wb_dat_i[TW-1:0];
                SEL_W'(REG_TRST):  r_d.t_rst  = wb_dat_i[TW-1:0];
                SEL_W'(REG_TRREC): r_d.t_rrec = wb_dat_i[TW-1:0];
                default: ;
            endcase
        end

        // a completion in the same cycle as a clear wins
        r_d.done = (r_q.done && !clr_done) || done_evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wb_dat_o    = r_q.rdata;
    assign wb_ack_o    = r_q.ack;
    assign len_o       = r_q.len;
    assign t_one_o     = r_q.t_one;
    assign t_zero_o    = r_q.t_zero;
    assign t_gap_o     = r_q.t_gap;
    assign t_rst_o     = r_q.t_rst;
    assign t_rrec_o    = r_q.t_rrec;
    assign done_o      = r_q.done;
    assign buf_we_o    = wr && is_buf;
    assign buf_widx_o  = wb_adr_i[IDX_W-1:0];
    assign buf_wdata_o = wb_dat_i[7:0];

endmodule

// File: rtl/owire_seq_engine.sv
module owire_seq_engine
    import owire_pkg::*;
#(
    parameter int TW    = 16,
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             lrst_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic [TW-1:0]    t_one_i,
    input  logic [TW-1:0]    t_zero_i,
    input  logic [TW-1:0]    t_gap_i,
    input  logic [TW-1:0]    t_rst_i,
    input  logic [TW-1:0]    t_rrec_i,
    input  logic [7:0]       rd_byte_i,
    input  logic             line_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             drive_low_o,
    output logic             busy_o,
    output logic             done_evt_o,
    output logic             switch_evt_o,
    output logic [7:0]       rx_o
);

    typedef struct packed {
        eng_state_e       st;
        logic [TW-1:0]    cnt;
        logic [IDX_W-1:0] byte_idx;
        logic [2:0]       bit_idx;
        logic             arm;
        logic [7:0]       rx;
    } eng_t;

    eng_t e_d, e_q;

    logic [2:0] nbit;
    logic       last_byte;
    logic       gap_end;
    logic       seq_end;
    logic       rst_end;

    // cycles left after the first one; zero behaves as one
    function automatic logic [TW-1:0] span(input logic [TW-1:0] t);
        return (t == '0) ? '0 : t - TW'(1);
    endfunction

    always_comb begin
        e_d       = e_q;
        nbit      = e_q.bit_idx + 3'd1;
        last_byte = (({1'b0, e_q.byte_idx} + CNT_W'(1)) == len_i);
        gap_end   = (e_q.st == ENG_GAP) && (e_q.cnt == '0);
        seq_end   = gap_end && (e_q.bit_idx == 3'd7) && last_byte;
        rst_end   = (e_q.st == ENG_RREC) && (e_q.cnt == '0);

        case (e_q.st)
            ENG_IDLE: begin
                if (lrst_i) begin
                    e_d.st  = ENG_RLOW;
                    e_d.cnt = span(t_rst_i);
                end else if (go_i && (len_i != '0)) begin
                    e_d.st       = ENG_LOW;
                    e_d.cnt      = span(rd_byte_i[0] ? t_one_i : t_zero_i);
                    e_d.arm      = arm_i;
                    e_d.byte_idx = '0;
                    e_d.bit_idx  = '0;
                end
            end
            ENG_LOW: begin
                if (e_q.cnt == '0) begin
                    e_d.st  = ENG_GAP;
                    e_d.cnt = span(t_gap_i);
                end else begin
                    e_d.cnt = e_q.cnt - TW'(1);
                end
            end
            ENG_GAP: begin
                if (e_q.cnt != '0) begin
                    e_d.cnt = e_q.cnt - TW'(1);
                end else begin
                    e_d.rx = {line_i, e_q.rx[7:1]};
                    if (seq_end) begin
                        e_d.st       = ENG_IDLE;
                        e_d.byte_idx = '0;
                        e_d.bit_idx  = '0;
                    end else begin
                        e_d.st      = ENG_LOW;
                        e_d.bit_idx = nbit;
                        if (e_q.bit_idx == 3'd7) begin
                            e_d.byte_idx = e_q.byte_idx + IDX_W'(1);
                        end
                        e_d.cnt = span(rd_byte_i[nbit] ? t_one_i : t_zero_i);
                    end
                end
            end
            ENG_RLOW: begin
                if (e_q.cnt == '0) begin
                    e_d.st  = ENG_RREC;
                    e_d.cnt = span(t_rrec_i);
                end else begin
                    e_d.cnt = e_q.cnt - TW'(1);
                end
            end
            ENG_RREC: begin
                if (e_q.cnt == '0) begin
                    e_d.st = ENG_IDLE;
                end else begin
                    e_d.cnt = e_q.cnt - TW'(1);
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    // the buffer is read ahead so the next bit's width is known in the gap's last cycle
    assign rd_idx_o     = ((e_q.st == ENG_GAP) && (e_q.bit_idx == 3'd7))
                          ? e_q.byte_idx + IDX_W'(1) : e_q.byte_idx;
    assign drive_low_o  = (e_q.st == ENG_LOW) || (e_q.st == ENG_RLOW);
    assign busy_o       = (e_q.st != ENG_IDLE);
    assign done_evt_o   = seq_end || rst_end;
    assign switch_evt_o = seq_end && e_q.arm;
    assign rx_o         = e_q.rx;

endmodule

// File: rtl/owire_pin_mux.sv
module owire_pin_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic switch_evt_i,
    input  logic drive_low_i,
    input  logic pin_id_in,
    input  logic dbg_dio_out,
    input  logic dbg_dio_oe,
    input  logic dbg_clk_out,
    output logic pin_id_out,
    output logic pin_id_oe,
    output logic pin_pwr_out,
    output logic pin_pwr_oe,
    output logic dbg_dio_in,
    output logic line_o,
    output logic dbg_mode_o
);

    logic mode_d, mode_q;

    always_comb begin
        mode_d = mode_q || switch_evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        if (mode_q) begin
            pin_id_out  = dbg_dio_out;
            pin_id_oe   = dbg_dio_oe;
            pin_pwr_out = dbg_clk_out;
            pin_pwr_oe  = 1'b1;
            dbg_dio_in  = pin_id_in;
        end else begin
            pin_id_out  = 1'b0;
            pin_id_oe   = drive_low_i;
            pin_pwr_out = 1'b0;
            pin_pwr_oe  = 1'b0;
            dbg_dio_in  = 1'b1;
        end
    end

    assign line_o     = pin_id_in;
    assign dbg_mode_o = mode_q;

endmodule

// File: rtl/owire_seq_player.sv
module owire_seq_player #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int TW     = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    input  logic              pin_id_in,
    output logic              pin_id_out,
    output logic              pin_id_oe,
    output logic              pin_pwr_out,
    output logic              pin_pwr_oe,
    input  logic              dbg_dio_out,
    input  logic              dbg_dio_oe,
    input  logic              dbg_clk_out,
    output logic              dbg_dio_in
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic             go, lrst, arm;
    logic [CNT_W-1:0] len;
    logic [TW-1:0]    t_one, t_zero, t_gap, t_rst, t_rrec;
    logic             done, busy, dbg_mode;
    logic             done_evt, switch_evt, drive_low, line;
    logic [7:0]       rx;
    logic             buf_we;
    logic [IDX_W-1:0] buf_widx, rd_idx;
    logic [7:0]       buf_wdata, rd_byte;

    owire_seq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TW(TW),
        .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
        .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
        .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
        .busy_i(busy), .dbg_mode_i(dbg_mode), .rx_i(rx), .done_evt_i(done_evt),
        .go_o(go), .lrst_o(lrst), .arm_o(arm), .len_o(len),
        .t_one_o(t_one), .t_zero_o(t_zero), .t_gap_o(t_gap),
        .t_rst_o(t_rst), .t_rrec_o(t_rrec), .done_o(done),
        .buf_we_o(buf_we), .buf_widx_o(buf_widx), .buf_wdata_o(buf_wdata)
    );

    owire_seq_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) buf_i (
        .clk(clk), .rst_n(rst_n),
        .we_i(buf_we), .widx_i(buf_widx), .wdata_i(buf_wdata),
        .ridx_i(rd_idx), .rdata_o(rd_byte)
    );

    owire_seq_engine #(
        .TW(TW), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) eng_i (
        .clk(clk), .rst_n(rst_n),
        .go_i(go), .lrst_i(lrst), .arm_i(arm), .len_i(len),
        .t_one_i(t_one), .t_zero_i(t_zero), .t_gap_i(t_gap),
        .t_rst_i(t_rst), .t_rrec_i(t_rrec),
        .rd_byte_i(rd_byte), .line_i(line),
        .rd_idx_o(rd_idx), .drive_low_o(drive_low), .busy_o(busy),
        .done_evt_o(done_evt), .switch_evt_o(switch_evt), .rx_o(rx)
    );

    owire_pin_mux mux_i (
        .clk(clk), .rst_n(rst_n),
        .switch_evt_i(switch_evt), .drive_low_i(drive_low),
        .pin_id_in(pin_id_in),
        .dbg_dio_out(dbg_dio_out), .dbg_dio_oe(dbg_dio_oe), .dbg_clk_out(dbg_clk_out),
        .pin_id_out(pin_id_out), .pin_id_oe(pin_id_oe),
        .pin_pwr_out(pin_pwr_out), .pin_pwr_oe(pin_pwr_oe),
        .dbg_dio_in(dbg_dio_in), .line_o(line), .dbg_mode_o(dbg_mode)
    );

endmodule

// File: rtl/owire_seq_player_chk.sv
module owire_seq_player_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic dbg_mode,
    input logic pin_id_oe,
    input logic pin_id_out,
    input logic pin_pwr_oe,
    input logic wb_ack_o
);

    AST_NEVER_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode |-> (!pin_id_out && !pin_pwr_oe)); // R3

    AST_PULL_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && pin_id_oe) |-> busy); // R4

    AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R5

    AST_SWITCH_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode) |-> $fell(busy)); // R7

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |=> dbg_mode); // R7

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o); // R10

endmodule

bind owire_seq_player owire_seq_player_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dbg_mode(dbg_mode),
    .pin_id_oe(pin_id_oe), .pin_id_out(pin_id_out), .pin_pwr_oe(pin_pwr_oe),
    .wb_ack_o(wb_ack_o)
);

// File: tb/owire_seq_player_tb_top.sv
module owire_seq_player_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [4:0]  adr = '0;
    logic [31:0] dat = '0;
    logic [31:0] rdat;
    logic        ack;
    logic        id_out, id_oe, pwr_out, pwr_oe, dio_in;
    logic        dio_out = 1'b0, dio_oe = 1'b0, dclk = 1'b0;
    logic        acc_hold = 1'b0;
    logic        id_line;

    always #10 clk = ~clk;

    // wire with pull-up, optionally held low by the far end
    assign id_line = (id_oe ? id_out : 1'b1) & ~acc_hold;

    owire_seq_player dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_dat_i(dat), .wb_dat_o(rdat), .wb_ack_o(ack),
        .pin_id_in(id_line), .pin_id_out(id_out), .pin_id_oe(id_oe),
        .pin_pwr_out(pwr_out), .pin_pwr_oe(pwr_oe),
        .dbg_dio_out(dio_out), .dbg_dio_oe(dio_oe), .dbg_clk_out(dclk),
        .dbg_dio_in(dio_in)
    );

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // queue entry per cycle: 1 = pulled low, 0 = released, 2 = released and sampled
    int   q[$];
    bit   kind_seq = 1'b0;
    bit   arm_m = 1'b0, done_m = 1'b0, dbg_m = 1'b0;
    int   len_m = 0, t1_m = 0, t0_m = 0, tg_m = 0, tr_m = 0, trr_m = 0;
    int   bufm[16];
    logic [7:0] rx_m = 8'h00;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic void push_seq();
        for (int b = 0; b < len_m; b++) begin
            for (int i = 0; i < 8; i++) begin
                int w = eff(((bufm[b] >> i) & 1) != 0 ? t1_m : t0_m);
                for (int k = 0; k < w; k++) q.push_back(1);
                for (int k = 0; k < eff(tg_m) - 1; k++) q.push_back(0);
                q.push_back(2);
            end
        end
    endfunction

    function automatic void push_rst();
        for (int k = 0; k < eff(tr_m); k++) q.push_back(1);
        for (int k = 0; k < eff(trr_m); k++) q.push_back(0);
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) bufm[i] = 0;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            bit busy_before;
            bit wr;
            int code;
            busy_before = (q.size() != 0);
            wr = cyc && stb && we && !ack;
            if (wr && adr == 5'd1 && dat[1]) done_m = 1'b0;
            if (busy_before) begin
                code = q.pop_front();
                if (code == 2) rx_m = {id_line, rx_m[7:1]};
                if (q.size() == 0) begin
                    done_m = 1'b1;
                    if (kind_seq && arm_m) dbg_m = 1'b1;
                end
            end
            if (wr) begin
                if (adr >= 5'd16) begin
                    bufm[adr - 5'd16] = dat[7:0];
                end else begin
                    case (adr)
                        5'd0: begin
                            if (dat[1] && !busy_before) begin
                                kind_seq = 1'b0;
                                push_rst();
                            end else if (dat[0] && !busy_before && len_m != 0) begin
                                kind_seq = 1'b1;
                                arm_m = dat[2];
                                push_seq();
                            end
                        end
                        5'd2: len_m = (dat > 32'd16) ? 16 : int'(dat);
                        5'd3: t1_m  = int'(dat[15:0]);
                        5'd4: t0_m  = int'(dat[15:0]);
                        5'd5: tg_m  = int'(dat[15:0]);
                        5'd6: tr_m  = int'(dat[15:0]);
                        5'd7: trr_m = int'(dat[15:0]);
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-cycle pin comparison, away from both edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit exp_oe;
            string tag;
            tag = kind_seq ? "R2" : "R6";
            if (dbg_m) begin
                chk(id_oe == dio_oe, "R7", "id oe in debug mode", id_oe, dio_oe);
                chk(id_out == dio_out, "R7", "id out in debug mode", id_out, dio_out);
                chk(pwr_oe == 1'b1, "R7", "pwr oe in debug mode", pwr_oe, 1);
                chk(pwr_out == dclk, "R7", "pwr clock in debug mode", pwr_out, dclk);
                chk(dio_in == id_line, "R7", "debug data input", dio_in, id_line);
            end else begin
                exp_oe = (q.size() != 0) && (q[0] == 1);
                chk(id_oe == exp_oe, tag, "line pull-down", id_oe, exp_oe);
                chk(id_out == 1'b0, "R3", "id out value", id_out, 0);
                chk(pwr_oe == 1'b0, "R3", "pwr released", pwr_oe, 0);
                chk(dio_in == 1'b1, "R7", "debug input idle", dio_in, 1);
            end
        end
    end

    function automatic logic [31:0] stat_exp();
        return {16'h0, rx_m, 5'b0, dbg_m, done_m, (q.size() != 0)};
    endfunction

    task automatic wb_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; dat = d;
        @(negedge clk);
        chk(ack == 1'b1, "R10", "write ack", ack, 1);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R10", "ack width", ack, 0);
    endtask

    task automatic wb_read(input logic [4:0] a, output logic [31:0] d, output logic [31:0] st);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
        st = stat_exp();
        @(negedge clk);
        chk(ack == 1'b1, "R10", "read ack", ack, 1);
        d = rdat;
        cyc = 1'b0; stb = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R10", "ack width", ack, 0);
    endtask

    task automatic check_status(input string req, input string what);
        logic [31:0] d, e;
        wb_read(5'd1, d, e);
        chk(d == e, req, what, d, e);
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 40000 && !finished) begin
            finished = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 40000 cycles", cycles);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(id_oe == 1'b0 && pwr_oe == 1'b0, "R1", "pins released", {id_oe, pwr_oe}, 0);
        chk(dio_in == 1'b1, "R1", "debug input", dio_in, 1);
        wb_read(5'd1, d, e);
        chk(d == 32'h0, "R1", "status after reset", d, 0);

        wb_write(5'd3, 32'd2);
        wb_write(5'd4, 32'd5);
        wb_write(5'd5, 32'd3);
        wb_write(5'd6, 32'd20);
        wb_write(5'd7, 32'd6);
        wb_read(5'd4, d, e);
        chk(d == 32'd5, "R10", "T_ZERO readback", d, 5);
        wb_read(5'd6, d, e);
        chk(d == 32'd20, "R10", "T_RST readback", d, 20);

        // R2 debug-entry pattern without arm
        wb_write(5'd16, 32'h75);
        wb_write(5'd17, 32'hA0);
        wb_write(5'd2, 32'd2);
        wb_write(5'd0, 32'h1);
        check_status("R4", "busy during run");
        wb_write(5'd0, 32'h1);  // R4: start while busy ignored
        wb_write(5'd0, 32'h2);  // R4: reset while busy ignored
        wait_idle();
        check_status("R9", "done, no switch, rx all ones");
        chk(dbg_m == 1'b0, "R7", "no switch without arm", dbg_m, 0);

        // R5 clear done
        wb_write(5'd1, 32'h2);
        check_status("R5", "done cleared");

        // R6 line reset, then both bits: reset wins
        wb_write(5'd0, 32'h2);
        wait_idle();
        check_status("R6", "done after line reset");
        wb_write(5'd1, 32'h2);
        wb_write(5'd0, 32'h3);
        wait_idle();
        check_status("R6", "reset priority over start");

        // R4 zero length ignored
        wb_write(5'd1, 32'h2);
        wb_write(5'd2, 32'd0);
        wb_write(5'd0, 32'h1);
        check_status("R4", "zero length start ignored");

        // R8 zero timings, R9 far end holds line low
        wb_write(5'd3, 32'd0);
        wb_write(5'd4, 32'd0);
        wb_write(5'd5, 32'd0);
        wb_write(5'd16, 32'h5A);
        wb_write(5'd2, 32'd1);
        acc_hold = 1'b1;
        wb_write(5'd0, 32'h1);
        wait_idle();
        acc_hold = 1'b0;
        check_status("R9", "rx all zeros with line held");

        // R2 length saturates at depth
        wb_write(5'd3, 32'd1);
        wb_write(5'd4, 32'd2);
        wb_write(5'd5, 32'd1);
        for (int i = 0; i < 16; i++) wb_write(5'(16 + i), 32'((i * 37 + 3) & 8'hFF));
        wb_write(5'd2, 32'd31);
        wb_read(5'd2, d, e);
        chk(d == 32'd16, "R2", "LEN saturated", d, 16);
        wb_write(5'd0, 32'h1);
        wait_idle();
        check_status("R2", "status after full buffer");

        // R7 armed debug-entry sequence
        wb_write(5'd3, 32'd3);
        wb_write(5'd4, 32'd7);
        wb_write(5'd5, 32'd2);
        wb_write(5'd16, 32'h75);
        wb_write(5'd17, 32'hA0);
        wb_write(5'd2, 32'd2);
        wb_write(5'd0, 32'h5);
        wait_idle();
        check_status("R7", "debug mode after armed sequence");
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            dio_oe = i[0]; dio_out = i[1]; dclk = i[2]; acc_hold = i[3];
        end
        @(negedge clk);
        acc_hold = 1'b0;
        check_status("R7", "debug mode held");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule